// File: doc/BRIEF.md
# Per-Channel Offset and Gain Trim

This block corrects raw 24-bit conversion results one sample at a time. Each sample comes with a valid strobe and a channel index. The block uses the index to pick that channel's offset word, gain word and output-format bit from static configuration buses. It first removes the offset from the sample, then scales the difference by the gain. The gain code 400000h means a gain of exactly 1. The result is rounded, clipped to 24 bits, and presented either as two's complement or as offset (straight) binary.

Samples arrive left-justified, so they line up with the 24-bit offset word. With the power-up calibration values (offset 0, gain 400000h, two's-complement format) a sample leaves the block unchanged. The path has three register stages, so a new sample can enter on every clock cycle.

Top module: `cal_trim`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `out_valid` is 0 and `out_data` is 000000h.
- R2: A sample accepted on the clock edge that ends cycle n appears, with `out_valid` high for one cycle, in cycle n+3. Back-to-back samples are accepted on every cycle.
- R3: The offset word of the selected channel is a 24-bit two's-complement value and is subtracted from the sample.
- R4: The difference is multiplied by the channel's gain word, an unsigned 24-bit value, and divided by 2^22, so that 400000h is unity gain.
- R5: The offset is removed before the gain is applied: result = (sample − offset) × gain / 2^22.
- R6: The scaled value is rounded by adding 2^21 to the full product and then shifting it right arithmetically by 22. Exact halves therefore round toward +infinity.
- R7: A result above 7FFFFFh is clipped to 7FFFFFh, and a result below −800000h is clipped to 800000h. Results never wrap.
- R8: When a channel's format bit in `fmt_sel` is 0, the output is two's complement. When the bit is 1, bit 23 of the clipped result is inverted, which gives straight binary.
- R9: A channel with offset 000000h, gain 400000h and format 0 outputs each sample unchanged.
- R10: While `out_valid` is low after a result, `out_data` keeps the last result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Sample strobe |
| in_chan | input | 3 | Channel index of the sample |
| in_data | input | 24 | Left-justified two's-complement sample |
| ofs_words | input | 192 | Offset words, channel k in bits [24k+23:24k] |
| gain_words | input | 192 | Gain words, channel k in bits [24k+23:24k] |
| fmt_sel | input | 8 | Output format per channel, bit k for channel k |
| out_valid | output | 1 | Result strobe |
| out_data | output | 24 | Corrected result |

## Verification
The assertions assume that `ofs_words`, `gain_words` and `fmt_sel` stay constant while samples are in the pipeline, because the words are sampled only on the first stage. The bench sets all calibration words once, before reset is released, and never changes them afterwards. As a result, every channel's settings are the same for each sample that uses them. The clipping checks also assume that the full product fits the internal width, which always holds for 24-bit operands. The stimulus deliberately reaches both clip limits and exact rounding halves of both signs.

// File: rtl/cal_trim.sv
module cal_trim #(
  parameter int NCH = 8,
  parameter int DW  = 24,
  localparam int CW   = $clog2(NCH),
  localparam int FRAC = DW - 2,
  localparam int PW   = 2 * DW + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [CW-1:0]     in_chan,
  input  logic [DW-1:0]     in_data,
  input  logic [NCH*DW-1:0] ofs_words,
  input  logic [NCH*DW-1:0] gain_words,
  input  logic [NCH-1:0]    fmt_sel,
  output logic              out_valid,
  output logic [DW-1:0]     out_data
);
  localparam logic signed [PW-1:0] HALF = PW'(1) <<< (FRAC - 1);
  localparam logic signed [PW-1:0] TOPV = PW'((2 ** (DW - 1)) - 1);
  localparam logic signed [PW-1:0] BOTV = -PW'(2 ** (DW - 1));
  localparam logic [DW-1:0] UNITY = DW'(1) << FRAC;

  logic [DW-1:0] ofs_pick, gain_pick;
  assign ofs_pick  = ofs_words[in_chan*DW +: DW];
  assign gain_pick = gain_words[in_chan*DW +: DW];

  logic                 v1, v2;
  logic signed [DW:0]   diff1;
  logic [DW-1:0]        gain1;
  logic                 fmt1, fmt2;
  logic signed [PW-1:0] prod2;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v1 <= 1'b0;
      diff1 <= '0;
      gain1 <= '0;
      fmt1 <= 1'b0;
    end else begin
      v1 <= in_valid;
      if (in_valid) begin
        diff1 <= $signed({in_data[DW-1], in_data}) - $signed({ofs_pick[DW-1], ofs_pick});
        gain1 <= gain_pick;
        fmt1  <= fmt_sel[in_chan];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v2 <= 1'b0;
      prod2 <= '0;
      fmt2 <= 1'b0;
    end else begin
      v2 <= v1;
      if (v1) begin
        prod2 <= diff1 * $signed({1'b0, gain1});
        fmt2  <= fmt1;
      end
    end
  end

  logic signed [PW-1:0] scaled;
  logic [DW-1:0]        clip;
  assign scaled = (prod2 + HALF) >>> FRAC;
  assign clip = (scaled > TOPV) ? {1'b0, {(DW-1){1'b1}}} :
                (scaled < BOTV) ? {1'b1, {(DW-1){1'b0}}} :
                scaled[DW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data <= '0;
    end else begin
      out_valid <= v2;
      if (v2) out_data <= {clip[DW-1] ^ fmt2, clip[DW-2:0]};
    end
  end

  logic [1:0] age;
  always_ff @(posedge clk) begin
    if (!rst_n) age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  logic unity_in;
  assign unity_in = in_valid && ofs_pick == '0 && gain_pick == UNITY && !fmt_sel[in_chan];

  assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd3) |-> (out_valid == $past(in_valid, 3)));

  assert_passthru_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd3 && $past(unity_in, 3)) |-> (out_data == $past(in_data, 3)));

  assert_clip_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (v2 && scaled > TOPV) |=> (out_valid && out_data[DW-2:0] == {(DW-1){1'b1}}
                               && out_data[DW-1] == $past(fmt2)));

  assert_clip_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (v2 && scaled < BOTV) |=> (out_valid && out_data[DW-2:0] == '0
                               && out_data[DW-1] == !$past(fmt2)));

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (age != 2'd0 && !$past(out_valid) && !out_valid) |-> $stable(out_data));
endmodule

// File: tb/cal_trim_test.sv
module cal_trim_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [2:0] in_chan = '0;
  logic [23:0] in_data = '0;
  logic out_valid;
  logic [23:0] out_data;
  int checks = 0;
  int fails = 0;

  localparam logic [191:0] OFS = {24'h000000, 24'h000000, 24'hFFFF00, 24'h000000,
                                  24'h000010, 24'h000000, 24'h000100, 24'h000000};
  localparam logic [191:0] GAIN = {24'h000001, 24'h400000, 24'h400000, 24'h800000,
                                   24'h600000, 24'h200000, 24'h400000, 24'h400000};
  localparam logic [7:0] FMT = 8'b0110_0000;

  localparam int NV = 18;
  localparam logic [50:0] VEC [NV] = '{
    {3'd0, 24'h123456, 24'h123456},
    {3'd0, 24'h800000, 24'h800000},
    {3'd1, 24'h001000, 24'h000F00},
    {3'd1, 24'h800050, 24'h800000},
    {3'd2, 24'h000101, 24'h000081},
    {3'd2, 24'hFFFEFF, 24'hFFFF80},
    {3'd3, 24'h000030, 24'h000030},
    {3'd3, 24'h000000, 24'hFFFFE8},
    {3'd4, 24'h400000, 24'h7FFFFF},
    {3'd4, 24'h3FFFFF, 24'h7FFFFE},
    {3'd4, 24'hC00000, 24'h800000},
    {3'd4, 24'hBFFFFF, 24'h800000},
    {3'd5, 24'h000000, 24'h800100},
    {3'd6, 24'h800000, 24'h000000},
    {3'd7, 24'h200000, 24'h000001},
    {3'd7, 24'h1FFFFF, 24'h000000},
    {3'd7, 24'hE00000, 24'h000000},
    {3'd7, 24'hDFFFFF, 24'hFFFFFF}
  };

  function automatic string tag_of(int i);
    case (i)
      0, 1: return "R9";
      2: return "R3";
      3: return "R3/R7";
      4, 5: return "R4/R6";
      6, 7: return "R5";
      8, 9, 10, 11: return "R7";
      12, 13: return "R8";
      default: return "R6";
    endcase
  endfunction

  cal_trim uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_chan(in_chan), .in_data(in_data),
    .ofs_words(OFS), .gain_words(GAIN), .fmt_sel(FMT),
    .out_valid(out_valid), .out_data(out_data)
  );

  always #10 clk = ~clk;

  task automatic check(string tag, logic [24:0] act, logic [24:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  initial begin : watchdog
    #2_000_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset", {out_valid, out_data}, {1'b0, 24'h0});
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after reset", {out_valid, out_data}, {1'b0, 24'h0});

    // R2: single sample, output exactly three cycles later
    in_valid = 1'b1; in_chan = 3'd1; in_data = 24'h000200;
    @(negedge clk);
    in_valid = 1'b0; in_data = 24'h0;
    @(negedge clk);
    check("R2 not early", {24'h0, out_valid}, 25'd0);
    @(negedge clk);
    check("R2 on time", {out_valid, out_data}, {1'b1, 24'h000100});
    @(negedge clk);
    check("R2 one cycle", {24'h0, out_valid}, 25'd0);
    check("R10 hold", {1'b0, out_data}, {1'b0, 24'h000100});

    // streamed vectors, back to back
    for (int k = 0; k < NV + 3; k++) begin
      if (k >= 3)
        check(tag_of(k - 3), {out_valid, out_data}, {1'b1, VEC[k-3][23:0]});
      if (k < NV) begin
        in_valid = 1'b1;
        in_chan = VEC[k][50:48];
        in_data = VEC[k][47:24];
      end else begin
        in_valid = 1'b0;
        in_data = 24'hABCDEF;
      end
      @(negedge clk);
    end
    in_valid = 1'b0;
    repeat (2) @(negedge clk);
    check("R10 idle hold", {out_valid, out_data}, {1'b0, VEC[NV-1][23:0]});

    // R8: format bit flips only the sign bit, max positive in straight binary
    in_valid = 1'b1; in_chan = 3'd6; in_data = 24'h7FFFFF;
    @(negedge clk);
    in_valid = 1'b0;
    repeat (2) @(negedge clk);
    check("R8 top code", {out_valid, out_data}, {1'b1, 24'hFFFFFF});

    // R1: reset mid-stream clears output
    in_valid = 1'b1; in_chan = 3'd0; in_data = 24'h555555;
    @(negedge clk);
    in_valid = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 mid reset", {out_valid, out_data}, {1'b0, 24'h0});
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 flushed", {out_valid, out_data}, {1'b0, 24'h0});

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule